// File: doc/BRIEF.md
# Serial Register Port with Burst and FIFO Streaming

This block is a serial slave port for a four-wire, mode-0 style bus. A host selects the block by pulling `sel_n` low and then shifts a header byte on `sdi`, most significant bit first. The first header bit is a direction flag and the next seven bits are a register address. The bytes that follow are written into a bank of 128 eight-bit registers, or read from it on `sdo`. The block oversamples the serial lines with its own clock. `sclk` must therefore run well below `clk`.

While `sel_n` stays low, every further group of eight `sclk` cycles moves one more byte. The address steps forward after each byte, so one header serves a whole run of registers. Address 7Fh works differently. It is a window onto an external show-ahead receive FIFO, so each byte read there consumes the FIFO head instead of repeating a value. Address 00h holds a fixed device-type code. Every accepted register write is also announced on a one-cycle strobe, so the rest of the chip can act on it.

Top module: `spi_regbank_slave`

## Requirements
- R1: A transaction begins with a header byte whose first bit (bit 7) is the direction flag, 1 for write and 0 for read. Its remaining bits are the 7-bit address, most significant bit first. `sdi` is sampled on rising `sclk` edges.
- R2: In a read, each data byte appears on `sdo` most significant bit first. Every bit changes after a falling `sclk` edge and is stable for the next rising edge. Whatever the host drives on `sdi` during a read leaves every register unchanged.
- R3: In a write burst, each completed data byte goes to the current address, and `reg_wr_stb` pulses for exactly one `clk` cycle with that address and byte on `reg_wr_addr`/`reg_wr_data`.
- R4: Apart from address 7Fh, the address increases by one after every completed data byte of a read or write burst. Once it reaches 7Fh, it stays there.
- R5: Each completed read byte at address 7Fh returns the current FIFO head and pulses `fifo_pop` for one cycle, so a burst returns the FIFO bytes in order without incrementing the address.
- R6: A byte read at 7Fh while `fifo_empty` is high returns 00h and does not pop. After that byte, `fifo_uflow` goes high and stays high until the next falling edge of `sel_n`.
- R7: Address 00h always reads 08h. Writes to 00h or 7Fh are dropped and produce no strobe.
- R8: If `sel_n` rises before the eighth bit of a byte, that byte is discarded. No write and no FIFO pop takes effect.
- R9: After reset, registers 01h to 7Eh read 00h and no strobe or pop is active.
- R10: `sdo` is low whenever `sel_n` has been high for at least four `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| sel_n | input | 1 | Active-low transaction select |
| sdo | output | 1 | Serial data to the host |
| fifo_data | input | 8 | Head byte of the receive FIFO (show-ahead) |
| fifo_empty | input | 1 | Receive FIFO holds no data |
| fifo_pop | output | 1 | One-cycle request to drop the FIFO head |
| fifo_uflow | output | 1 | A FIFO read found the FIFO empty |
| reg_wr_stb | output | 1 | One-cycle pulse for each accepted register write |
| reg_wr_addr | output | 7 | Address of the accepted write |
| reg_wr_data | output | 8 | Data of the accepted write |

## Verification
The assertions assume that the FIFO changes only when the block pops it, so a byte loaded from a non-empty FIFO is still there when the pop is issued. They also assume the serial lines move slowly enough that at least a few `clk` cycles separate any two `sclk` edges. The bench meets both conditions: it owns a small FIFO model that changes only on pops and on pushes made between transactions. It also holds every `sclk` level for eight `clk` cycles and changes `sdi` and `sel_n` only while `sclk` is low.

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  DEV_ID = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              sel_n,
  output logic              sdo,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic              fifo_uflow,
  output logic              reg_wr_stb,
  output logic [DATA_W-2:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data
);
  localparam int ADDR_W = DATA_W - 1;
  localparam int NREG   = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] FIFO_ADDR = {ADDR_W{1'b1}};
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);

  logic [2:0] sclk_s, sel_s;
  logic [1:0] sdi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      sel_s  <= '1;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      sel_s  <= {sel_s[1:0], sel_n};
      sdi_s  <= {sdi_s[0], sdi};
    end

  wire active   = ~sel_s[1];
  wire rise     = sclk_s[1] & ~sclk_s[2];
  wire fall     = ~sclk_s[1] & sclk_s[2];
  wire sel_fall = ~sel_s[1] & sel_s[2];

  logic [CNT_W-1:0]  cnt;
  logic              in_data, is_read, ld_fifo, ld_empty, uflow;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] sh, tx;
  logic [DATA_W-1:0] regs [0:NREG-1];
  logic [DATA_W-1:0] rd_val;

  wire [DATA_W-1:0] next_sh  = {sh[DATA_W-2:0], sdi_s[1]};
  wire              wr_legal = (addr != '0) && (addr != FIFO_ADDR);

  always_comb
    if (addr == '0)             rd_val = DEV_ID;
    else if (addr == FIFO_ADDR) rd_val = fifo_empty ? '0 : fifo_data;
    else                        rd_val = regs[addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt         <= '0;
      in_data     <= 1'b0;
      is_read     <= 1'b0;
      ld_fifo     <= 1'b0;
      ld_empty    <= 1'b0;
      uflow       <= 1'b0;
      addr        <= '0;
      sh          <= '0;
      tx          <= '0;
      fifo_pop    <= 1'b0;
      reg_wr_stb  <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      reg_wr_stb <= 1'b0;
      fifo_pop   <= 1'b0;
      if (sel_fall) uflow <= 1'b0;
      if (!active) begin
        cnt      <= '0;
        in_data  <= 1'b0;
        is_read  <= 1'b0;
        ld_fifo  <= 1'b0;
        ld_empty <= 1'b0;
        tx       <= '0;
      end else begin
        if (rise) begin
          sh  <= next_sh;
          cnt <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            if (!in_data) begin
              in_data <= 1'b1;
              is_read <= ~next_sh[DATA_W-1];
              addr    <= next_sh[ADDR_W-1:0];
            end else begin
              if (!is_read && wr_legal) begin
                regs[addr]  <= next_sh;
                reg_wr_stb  <= 1'b1;
                reg_wr_addr <= addr;
                reg_wr_data <= next_sh;
              end
              if (is_read && ld_fifo)  fifo_pop <= 1'b1;
              if (is_read && ld_empty) uflow    <= 1'b1;
              if (addr != FIFO_ADDR)   addr     <= addr + 1'b1;
            end
          end
        end
        if (fall && in_data && is_read) begin
          if (cnt == '0) begin
            tx       <= rd_val;
            ld_fifo  <= (addr == FIFO_ADDR) && !fifo_empty;
            ld_empty <= (addr == FIFO_ADDR) && fifo_empty;
          end else begin
            tx <= {tx[DATA_W-2:0], 1'b0};
          end
        end
      end
    end

  assign sdo        = tx[DATA_W-1];
  assign fifo_uflow = uflow;
endmodule

module spi_regbank_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              sdo,
  input logic              fifo_pop,
  input logic              fifo_empty,
  input logic              reg_wr_stb,
  input logic [DATA_W-2:0] reg_wr_addr
);
  a_r3_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |=> !reg_wr_stb);

  a_r7_wr_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |-> (reg_wr_addr != '0) && (reg_wr_addr != '1));

  a_r5_pop_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  a_r6_pop_only_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  a_r10_sdo_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n && $past(sel_n) && $past(sel_n, 2) && $past(sel_n, 3) |-> !sdo);
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sdo(sdo),
  .fifo_pop(fifo_pop), .fifo_empty(fifo_empty),
  .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr)
);

// File: tb/test_spi_regbank_slave.sv
`timescale 1ns/1ps
module test_spi_regbank_slave;
  localparam int T = 20;
  localparam int H = 8 * T;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, sel_n = 1'b1;
  logic sdo, fifo_pop, fifo_uflow, reg_wr_stb;
  logic [6:0] reg_wr_addr;
  logic [7:0] reg_wr_data, fifo_data;
  logic fifo_empty;

  always #(T/2) clk = ~clk;

  spi_regbank_slave i_spi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .sel_n(sel_n), .sdo(sdo),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .fifo_uflow(fifo_uflow), .reg_wr_stb(reg_wr_stb),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
  );

  // receive FIFO model, show-ahead
  logic [7:0] fq [0:15];
  int fhead = 0, fcnt = 0, pops = 0, strobes = 0;
  logic push_en = 1'b0;
  logic [7:0] push_v = '0;
  logic [6:0] last_wa;
  logic [7:0] last_wd;
  assign fifo_data  = fq[fhead];
  assign fifo_empty = (fcnt == 0);

  always @(posedge clk) begin
    if (push_en) fq[(fhead + fcnt) % 16] <= push_v;
    if (fifo_pop && fcnt > 0) begin
      fhead <= (fhead + 1) % 16;
      pops  <= pops + 1;
    end
    fcnt <= fcnt + (push_en ? 1 : 0) - ((fifo_pop && fcnt > 0) ? 1 : 0);
    if (reg_wr_stb) begin
      strobes <= strobes + 1;
      last_wa <= reg_wr_addr;
      last_wd <= reg_wr_data;
    end
  end

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] expr [0:127];
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); push_en = 1'b1; push_v = v;
    @(negedge clk); push_en = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      sdi = o[b]; #(H);
      i[b] = sdo; sclk = 1'b1; #(H);
      sclk = 1'b0;
    end
  endtask

  task automatic sbegin(); @(negedge clk); sel_n = 1'b0; #(H); endtask
  task automatic send(); #(H); sel_n = 1'b1; #(4*H); endtask

  task automatic wr_burst(input logic [6:0] a, input int n);
    logic [7:0] d;
    logic [6:0] cur;
    sbegin(); xfer({1'b1, a}, d);
    for (int k = 0; k < n; k++) xfer(wbuf[k], d);
    send();
    cur = a;
    for (int k = 0; k < n; k++) begin
      if (cur != 7'h00 && cur != 7'h7F) expr[cur] = wbuf[k];
      if (cur != 7'h7F) cur = cur + 7'd1;
    end
  endtask

  task automatic rd_burst(input logic [6:0] a, input int n);
    logic [7:0] d;
    sbegin(); xfer({1'b0, a}, d);
    for (int k = 0; k < n; k++) xfer(8'($urandom), rbuf[k]);
    send();
  endtask

  task automatic abort_after(input logic [7:0] hdr, input int nbits);
    logic [7:0] d;
    sbegin(); xfer(hdr, d);
    for (int b = 0; b < nbits; b++) begin
      sdi = 1'($urandom); #(H); sclk = 1'b1; #(H); sclk = 1'b0;
    end
    #(H); sel_n = 1'b1; #(4*H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0, p0, n;
    logic [6:0] a;
    logic [7:0] v [0:3];
    void'($urandom(32'd4330));
    for (int i = 0; i < 128; i++) expr[i] = 8'h00;
    expr[0] = 8'h08;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R10 sdo idle after reset", {7'd0, sdo}, 8'h00);
    check("R9 no strobe after reset", {7'd0, reg_wr_stb}, 8'h00);
    rd_burst(7'h01, 1); check("R9 reg 01h reset value", rbuf[0], 8'h00);
    rd_burst(7'h7E, 1); check("R9 reg 7Eh reset value", rbuf[0], 8'h00);
    rd_burst(7'h00, 1); check("R7 device type", rbuf[0], 8'h08);

    s0 = strobes;
    wbuf[0] = 8'h5A; wr_burst(7'h00, 1);
    check("R7 write to 00h no strobe", 8'(strobes - s0), 8'h00);
    rd_burst(7'h00, 1); check("R7 00h unchanged", rbuf[0], 8'h08);
    p0 = pops;
    wbuf[0] = 8'h33; wr_burst(7'h7F, 1);
    check("R7 write to 7Fh no strobe", 8'(strobes - s0), 8'h00);
    check("R7 write to 7Fh no pop", 8'(pops - p0), 8'h00);

    wbuf[0] = 8'hA5; wr_burst(7'h05, 1);
    check("R1 R3 one strobe", 8'(strobes - s0), 8'h01);
    check("R3 strobe addr", {1'b0, last_wa}, 8'h05);
    check("R3 strobe data", last_wd, 8'hA5);
    rd_burst(7'h05, 1); check("R1 R2 readback", rbuf[0], 8'hA5);
    rd_burst(7'h05, 1); check("R2 sdi ignored on read", rbuf[0], 8'hA5);

    for (int it = 0; it < 30; it++) begin
      n = 1 + int'($urandom % 4);
      a = 7'(1 + ($urandom % (127 - n)));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      s0 = strobes;
      wr_burst(a, n);
      check("R3 burst strobe count", 8'(strobes - s0), 8'(n));
      rd_burst(a, n);
      for (int k = 0; k < n; k++) check("R4 burst readback", rbuf[k], expr[a + 7'(k)]);
      a = 7'(1 + ($urandom % 126));
      rd_burst(a, 1); check("R2 random single read", rbuf[0], expr[a]);
    end

    for (int k = 0; k < 4; k++) begin v[k] = 8'($urandom); push(v[k]); end
    p0 = pops;
    rd_burst(7'h7F, 4);
    for (int k = 0; k < 4; k++) check("R5 FIFO order", rbuf[k], v[k]);
    check("R5 pop count", 8'(pops - p0), 8'h04);
    check("R5 no underflow", {7'd0, fifo_uflow}, 8'h00);

    rd_burst(7'h7F, 1);
    check("R6 empty read value", rbuf[0], 8'h00);
    check("R6 underflow raised", {7'd0, fifo_uflow}, 8'h01);
    check("R6 no pop when empty", 8'(pops - p0), 8'h04);
    rd_burst(7'h01, 1);
    check("R6 underflow cleared by select", {7'd0, fifo_uflow}, 8'h00);

    s0 = strobes;
    abort_after({1'b1, 7'h10}, 4);
    check("R8 aborted write no strobe", 8'(strobes - s0), 8'h00);
    rd_burst(7'h10, 1); check("R8 aborted write no change", rbuf[0], expr[16]);
    push(8'hC3);
    p0 = pops;
    abort_after({1'b0, 7'h7F}, 3);
    check("R8 aborted FIFO read no pop", 8'(pops - p0), 8'h00);
    rd_burst(7'h7F, 1); check("R5 FIFO head kept after abort", rbuf[0], 8'hC3);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h44;
    s0 = strobes;
    wr_burst(7'h7D, 3);
    check("R4 burst stops at 7Fh", 8'(strobes - s0), 8'h02);
    rd_burst(7'h7E, 1); check("R4 burst into 7Eh", rbuf[0], 8'h22);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule